// File: doc/BRIEF.md
# Programmable Slot-Table Memory Arbiter

This block decides, once per clock, which of up to sixteen requesters may use a single shared memory port. It does not rotate through the requesters in a fixed order. Instead it walks a circular table of slot entries. Each entry names one requester, or is marked empty. A read pointer advances by one entry on every clock and returns to entry 0 after the last active entry. Software sets the number of active entries, called the length N, anywhere from 1 up to the full table depth.

Because the table is written by software, the arbiter supports several schedules. A requester listed in more entries gets a larger share of the bandwidth. Empty entries give idle cycles. With N equal to 1, a single requester owns every cycle. A length that matches the number of requesters in use gives an evenly repeating, jitter-free pattern. Entries at or beyond N keep their contents, so a larger N restores the old schedule without any rewrites.

Two plain write strobes configure the table: one for a single entry and one for the length. The outputs are a one-hot grant vector and the owner of the current slot. Every interface is a control or status pin. There is no valid/ready stream here and no back-pressure: grants cannot be stalled, and a slot whose owner is not requesting is lost.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, table entry i is valid with owner ID (i mod 16), and the active length is 16 (length register value 15), so the first 16 cycles grant owners 0,1,...,15 in order.
- R2: The pointer starts at entry 0 after reset. It advances by one entry per clock and returns to entry 0 on the clock after it selects entry N-1.
- R3: `owner_valid` and `owner_id` show the selected entry combinationally. `grant` has bit `owner_id` set, and no other bit, exactly when the entry is valid and `req[owner_id]` is high.
- R4: If the selected entry is empty (valid bit 0), `owner_valid` is 0 and `grant` is all zero, whatever `req` is.
- R5: If the owner of a valid slot is not requesting, `grant` is all zero for that cycle, even when other requesters are active. The slot is not given to anyone else.
- R6: A length write (`len_we`, `len_m1` = N-1) is held as pending and becomes active only when the pointer wraps to entry 0. A write made in the cycle in which the pointer selects the last active entry applies at that same wrap. If several writes arrive before a wrap, the last one wins.
- R7: With `len_m1` = 0, entry 0 is selected on every cycle. Entries 1 and above keep their contents, and a later larger length brings their owners back.
- R8: An entry write (`ent_we`, `ent_addr`, `ent_valid`, `ent_id`) is visible from the next clock onward. In the cycle of the write, a read of that same entry still shows its old contents.
- R9: A requester ID placed in k of the N active entries receives exactly k grants in every N consecutive cycles while it requests continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 16 | Request line per requester |
| ent_we | input | 1 | Table entry write strobe |
| ent_addr | input | 5 | Entry index to write |
| ent_valid | input | 1 | Valid bit for written entry (0 = empty slot) |
| ent_id | input | 4 | Owner ID for written entry |
| len_we | input | 1 | Length write strobe |
| len_m1 | input | 5 | Requested active length minus one |
| grant | output | 16 | One-hot grant (all zero when no grant) |
| owner_valid | output | 1 | Selected entry is valid |
| owner_id | output | 4 | Owner ID of the selected entry |

## Verification
Two pairs of functions can land in the same cycle, and each is forced on purpose. The first pair is an entry write and the read of that same entry. The bench writes the entry the pointer is currently on and expects the old owner for that cycle and the new owner on the entry's next visit. The second pair is a length write and the wrap of the pointer. The bench issues the write exactly when its model's pointer is on the last active entry and expects the new length to govern the very next rotation. A behavioural model compares grant and owner outputs on every clock under directed and random writes, so a collision judged wrongly shows up as a mismatch in the following cycles.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ARB_NUM_REQ_DEF = 16;
  localparam int ARB_DEPTH_DEF   = 32;

  // Owner assigned to an entry by the equal-spread reset pattern
  function automatic int spread_owner(input int idx, input int nreq);
    return idx % nreq;
  endfunction
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int DEPTH   = 32,
  parameter int NUM_REQ = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_valid,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_valid,
  output logic [ID_W-1:0]  rd_id
);
  logic            ent_v  [DEPTH];
  logic [ID_W-1:0] ent_id [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[g]  <= 1'b1;
        ent_id[g] <= ID_W'(arb_pkg::spread_owner(g, NUM_REQ));
      end else if (wr_en && wr_addr == IDX_W'(g)) begin
        ent_v[g]  <= wr_valid;
        ent_id[g] <= wr_id;
      end
    end
  end

  // Read is from the registered array: a same-cycle write is not yet seen
  assign rd_valid = ent_v[rd_addr];
  assign rd_id    = ent_id[rd_addr];

  AST_ENTRY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_v[$past(wr_addr)] == $past(wr_valid)) &&
              (ent_id[$past(wr_addr)] == $past(wr_id))); // R8
endmodule

// File: rtl/slot_pointer.sv
module slot_pointer #(
  parameter int DEPTH     = 32,
  parameter int RESET_LEN = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic [IDX_W-1:0] len_m1,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] last_act;
  logic [IDX_W-1:0] last_pend;
  logic [IDX_W-1:0] last_next;
  logic             at_last;

  assign last_next = len_we ? len_m1 : last_pend;
  assign at_last   = (ptr == last_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      last_act  <= IDX_W'(RESET_LEN - 1);
      last_pend <= IDX_W'(RESET_LEN - 1);
    end else begin
      last_pend <= last_next;
      if (at_last) begin
        ptr      <= '0;
        last_act <= last_next;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= last_act); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != last_act) |=> (ptr == $past(ptr) + 1'b1)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == last_act) |=> (ptr == '0)); // R2
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != last_act) |=> $stable(last_act)); // R6
endmodule

// File: rtl/grant_decode.sv
module grant_decode #(
  parameter int NUM_REQ = 16,
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_valid,
  input  logic [ID_W-1:0]    sel_id,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
    assign grant[g] = sel_valid && (sel_id == ID_W'(g)) && req[g];
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0)); // R5
  AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (grant == '0)); // R4
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int NUM_REQ = arb_pkg::ARB_NUM_REQ_DEF,
  parameter int DEPTH   = arb_pkg::ARB_DEPTH_DEF,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ID_W   = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               ent_we,
  input  logic [IDX_W-1:0]   ent_addr,
  input  logic               ent_valid,
  input  logic [ID_W-1:0]    ent_id,
  input  logic               len_we,
  input  logic [IDX_W-1:0]   len_m1,
  output logic [NUM_REQ-1:0] grant,
  output logic               owner_valid,
  output logic [ID_W-1:0]    owner_id
);
  logic [IDX_W-1:0] ptr;

  slot_pointer #(.DEPTH(DEPTH), .RESET_LEN(NUM_REQ)) u_ptr (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_m1(len_m1), .ptr(ptr)
  );

  slot_table #(.DEPTH(DEPTH), .NUM_REQ(NUM_REQ)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_we), .wr_addr(ent_addr), .wr_valid(ent_valid), .wr_id(ent_id),
    .rd_addr(ptr), .rd_valid(owner_valid), .rd_id(owner_id)
  );

  grant_decode #(.NUM_REQ(NUM_REQ)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_valid(owner_valid), .sel_id(owner_id),
    .req(req), .grant(grant)
  );

  AST_GRANT_MATCHES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (owner_valid && grant[owner_id])); // R3
endmodule

// File: tb/tb_slot_arbiter.sv
`timescale 1ns/100ps
module tb_slot_arbiter;
  localparam int NR = 16;
  localparam int DP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] req = '0;
  logic          ent_we = 1'b0;
  logic [4:0]    ent_addr = '0;
  logic          ent_valid = 1'b0;
  logic [3:0]    ent_id = '0;
  logic          len_we = 1'b0;
  logic [4:0]    len_m1 = '0;
  logic [NR-1:0] grant;
  logic          owner_valid;
  logic [3:0]    owner_id;

  always #2 clk = ~clk; // 250 MHz

  slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ent_we(ent_we), .ent_addr(ent_addr),
    .ent_valid(ent_valid), .ent_id(ent_id), .len_we(len_we), .len_m1(len_m1),
    .grant(grant), .owner_valid(owner_valid), .owner_id(owner_id)
  );

  // Behavioural model
  int m_v[DP];
  int m_id[DP];
  int m_ptr, m_act, m_pend;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  int share_cnt;

  task automatic model_reset();
    for (int i = 0; i < DP; i++) begin m_v[i] = 1; m_id[i] = i % NR; end
    m_ptr = 0; m_act = NR - 1; m_pend = NR - 1;
  endtask

  task automatic model_step();
    int nxt;
    bit wrap;
    wrap = (m_ptr == m_act);
    if (ent_we) begin m_v[ent_addr] = ent_valid; m_id[ent_addr] = ent_id; end
    nxt = len_we ? int'(len_m1) : m_pend;
    m_pend = nxt;
    if (wrap) begin m_ptr = 0; m_act = nxt; end
    else m_ptr = m_ptr + 1;
  endtask

  task automatic compare(input string tag);
    logic [NR-1:0] eg;
    eg = '0;
    if (m_v[m_ptr] != 0 && req[m_id[m_ptr]]) eg[m_id[m_ptr]] = 1'b1;
    checks++;
    if (grant !== eg || owner_valid !== (m_v[m_ptr] != 0) ||
        (m_v[m_ptr] != 0 && owner_id !== 4'(m_id[m_ptr]))) begin
      fails++;
      $display("FAIL %s: grant=%h valid=%0b id=%0d expected grant=%h valid=%0d id=%0d",
               tag, grant, owner_valid, owner_id, eg, m_v[m_ptr], m_id[m_ptr]);
    end
  endtask

  // One cycle: inputs already set after the previous edge; compare, then clock
  task automatic cycle(input string tag);
    #0.5;
    compare(tag);
    if (grant == 16'h0200) share_cnt++;
    @(posedge clk);
    model_step();
    #1;
    ent_we = 1'b0; len_we = 1'b0;
  endtask

  task automatic wr_entry(input int a, input bit v, input int id);
    ent_we = 1'b1; ent_addr = 5'(a); ent_valid = v; ent_id = 4'(id);
  endtask

  task automatic wr_len(input int m1);
    len_we = 1'b1; len_m1 = 5'(m1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    req = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset fill, owners 0..15 in order
    for (int i = 0; i < 16; i++) cycle("R1");
    // R2: second rotation over the default length
    for (int i = 0; i < 20; i++) cycle("R2");
    // R5: only even requesters request; odd slots wasted
    req = 16'h5555;
    for (int i = 0; i < 20; i++) cycle("R5");
    req = '1;
    // R4: empty entries 3 and 7
    wr_entry(3, 0, 0); cycle("R4");
    wr_entry(7, 0, 5); cycle("R4");
    for (int i = 0; i < 20; i++) cycle("R4");
    // R6: length write mid-rotation, deferred to wrap
    wr_len(7);
    for (int i = 0; i < 24; i++) cycle("R6");
    // R6: length write in the exact wrap cycle
    while (m_ptr != m_act) cycle("R6");
    wr_len(11);
    for (int i = 0; i < 26; i++) cycle("R6");
    // R6: two writes before one wrap, last wins
    while (m_ptr == m_act) cycle("R6");
    wr_len(4); cycle("R6");
    if (m_ptr == m_act) cycle("R6");
    wr_len(9);
    for (int i = 0; i < 30; i++) cycle("R6");
    // R8: write the entry currently selected
    for (int k = 0; k < 4; k++) begin
      wr_entry(m_ptr, 1, 12 - k);
      for (int i = 0; i < 13; i++) cycle("R8");
    end
    // R7: single owner loop, then restore
    wr_len(0);
    for (int i = 0; i < 24; i++) cycle("R7");
    wr_len(15);
    for (int i = 0; i < 34; i++) cycle("R7");
    // R9: requester 9 in two of four entries gets half
    wr_entry(0, 1, 9); cycle("R9");
    wr_entry(1, 1, 1); cycle("R9");
    wr_entry(2, 1, 9); cycle("R9");
    wr_entry(3, 1, 4); cycle("R9");
    wr_len(3);
    for (int i = 0; i < 40; i++) cycle("R9");
    while (m_ptr != 0) cycle("R9");
    share_cnt = 0;
    for (int i = 0; i < 40; i++) cycle("R9");
    checks++;
    if (share_cnt != 20) begin
      fails++;
      $display("FAIL R9: grants to id 9 over 40 cycles = %0d expected 20", share_cnt);
    end
    // R3: random mix of requests and writes
    for (int i = 0; i < 600; i++) begin
      req = 16'($urandom);
      if ($urandom_range(0, 3) == 0)
        wr_entry($urandom_range(0, 31), $urandom_range(0, 5) != 0, $urandom_range(0, 15));
      if ($urandom_range(0, 19) == 0) wr_len($urandom_range(0, 31));
      cycle("R3");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule